// File: doc/BRIEF.md
# Paged Receive Buffer Ring Manager

This block generates write addresses for incoming packet bytes in a receive buffer that software treats as a ring of 256-byte pages. Four page registers define the ring and track how far it has been filled: ring start, ring end (the first page past the ring), a boundary page the writer must never enter, and the current page where the next packet begins. Bytes arrive as a stream with start-of-frame and end-of-frame marks, plus a good/bad verdict given with the final byte. Each byte goes out on a simple memory write port at an address that steps forward by one. At each page end the address moves to the next page, and past the last page it returns to ring start.

Every packet's data starts four bytes into its first page. Those four bytes are left for a header, which is written only when a packet is accepted. The header holds a status byte, the page where the following packet will start, and the total stored length including the header, least significant byte first. After the header the current page moves on and a one-cycle packet-received pulse is raised. A packet that is marked bad is abandoned, and the next packet reuses its start address. A packet that would write into the boundary page is cut off, and a one-cycle overwrite-warning pulse is raised. In both cases the current page stays where it was.

Top module: `rxring_mgr`

## Requirements
- R1: The first byte of a packet, sampled with rxValid and rxSof high outside a packet, is written at offset 4 of the current page. The memory write appears on the port one cycle after the byte is sampled.
- R2: Later bytes of the same packet are written at consecutive addresses. A byte following one written at offset 0xFF goes to offset 0x00 of the next page.
- R3: When the next page equals the ring-end register, writing continues at the ring-start page.
- R4: If a byte's target page equals the boundary register, that byte and all remaining bytes up to end of frame are not written. irqOverwrite pulses for one cycle, in a cycle with no memory write, and the current page does not change.
- R5: A packet whose final byte has rxGood low produces no header and no irqPktRcvd. The current page is unchanged, and the next packet starts again at offset 4 of that page.
- R6: For an accepted packet, the four cycles after the final data byte's write carry the header writes at offsets 0, 1, 2, 3 of the packet's first page. Their values are: status 0x01, next-packet page, total length low byte, total length high byte. The total length is the data byte count plus 4.
- R7: The next-packet page is the page after the one holding the last data byte, with ring wrap. irqPktRcvd pulses together with the offset-3 header write, and the current page takes the next-packet page from that cycle on.
- R8: rxValid beats without rxSof while no packet is in progress cause no memory write. rxValid beats during header writing are also ignored.
- R9: Registers are written with regWe and read combinationally on regRdata. The address map is 0 ring start, 1 ring end, 2 boundary, 3 current page. Reset values are 0x40, 0x80, 0x40, 0x41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | A received byte is present |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| rxGood | input | 1 | With rxEof: frame is accepted (1) or rejected (0) |
| rxData | input | 8 | Received byte |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 8 | Register write data (page number) |
| regRdata | output | 8 | Register read data |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | 16 | Buffer memory byte address |
| memData | output | 8 | Buffer memory write data |
| irqPktRcvd | output | 1 | One-cycle pulse per accepted packet |
| irqOverwrite | output | 1 | One-cycle pulse per packet cut off at the boundary |

## Verification
The bench targets four kinds of case:

- **Page-crossing and wrap edges.** It sends a packet that fills its page exactly to offset 0xFF, and a packet that crosses from the last ring page back to ring start. A design with an off-by-one in page linking would write a byte twice or skip to the wrong page, and the scoreboard would see a mismatched address.
- **Boundary cut-off in mid-packet and on a packet's first byte.** A wrong design would either overwrite the boundary page or advance the current page after the abort.
- **Rejected frame followed by a good one.** This catches a writer that fails to roll back and places the next packet after the discarded bytes.
- **Header contents.** The next-page and length bytes are checked against independently computed values. This exposes a length that leaves out the 4-byte header, or a next page that does not wrap.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_HDR
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       writeByte;  // write rxData at the target address, advance
    logic       useStart;   // target is the packet start in the current page
    logic       hdrWrite;   // write one header byte
    logic [1:0] hdrIdx;     // which header byte
    logic       commit;     // current page takes the next-packet page
    logic       rollback;   // write address returns to the packet start
    logic       overflow;   // boundary reached
  } ringCtl_t;

endpackage

// File: rtl/rxring_page_inc.sv
module rxring_page_inc #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] ringStart,
  input  logic [PAGE_W-1:0] ringEnd,
  output logic [PAGE_W-1:0] nextPage
);
  logic [PAGE_W-1:0] plusOne;

  always_comb begin
    plusOne  = page + {{(PAGE_W-1){1'b0}}, 1'b1};
    nextPage = (plusOne == ringEnd) ? ringStart : plusOne;
  end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxValid,
  input  logic     rxSof,
  input  logic     rxEof,
  input  logic     rxGood,
  input  logic     curHitsBnd,
  input  logic     wrHitsBnd,
  output ringCtl_t ctl
);
  rxState_e state, stateNext;
  logic [1:0] hdrCnt, hdrCntNext;

  always_comb begin
    ctl        = '0;
    stateNext  = state;
    hdrCntNext = hdrCnt;
    unique case (state)
      ST_IDLE: begin
        if (rxValid && rxSof) begin
          if (curHitsBnd) begin
            ctl.overflow = 1'b1;
            ctl.rollback = 1'b1;
            stateNext    = rxEof ? ST_IDLE : ST_DROP;
          end else begin
            ctl.writeByte = 1'b1;
            ctl.useStart  = 1'b1;
            if (rxEof) begin
              if (rxGood) begin
                stateNext  = ST_HDR;
                hdrCntNext = 2'd0;
              end else begin
                ctl.rollback = 1'b1;
                stateNext    = ST_IDLE;
              end
            end else begin
              stateNext = ST_RECV;
            end
          end
        end
      end
      ST_RECV: begin
        if (rxValid) begin
          if (wrHitsBnd) begin
            ctl.overflow = 1'b1;
            ctl.rollback = 1'b1;
            stateNext    = rxEof ? ST_IDLE : ST_DROP;
          end else begin
            ctl.writeByte = 1'b1;
            if (rxEof) begin
              if (rxGood) begin
                stateNext  = ST_HDR;
                hdrCntNext = 2'd0;
              end else begin
                ctl.rollback = 1'b1;
                stateNext    = ST_IDLE;
              end
            end
          end
        end
      end
      ST_DROP: begin
        if (rxValid && rxEof) stateNext = ST_IDLE;
      end
      ST_HDR: begin
        ctl.hdrWrite = 1'b1;
        ctl.hdrIdx   = hdrCnt;
        hdrCntNext   = hdrCnt + 2'd1;
        if (hdrCnt == 2'd3) begin
          ctl.commit   = 1'b1;
          ctl.rollback = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrCnt <= 2'd0;
    end else begin
      state  <= stateNext;
      hdrCnt <= hdrCntNext;
    end
  end
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          HDR_BYTES  = 4,
  parameter logic [7:0]  STATUS_OK  = 8'h01,
  parameter int          START_RST  = 'h40,
  parameter int          END_RST    = 'h80,
  parameter int          BND_RST    = 'h40,
  parameter int          CUR_RST    = 'h41,
  localparam int         PAGE_W     = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringCtl_t          ctl,
  input  logic [7:0]        rxData,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [PAGE_W-1:0] regWdata,
  output logic [PAGE_W-1:0] regRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              irqPktRcvd,
  output logic              irqOverwrite,
  output logic              curHitsBnd,
  output logic              wrHitsBnd,
  output logic [PAGE_W-1:0] curPageQ,
  output logic [PAGE_W-1:0] ringStartQ,
  output logic [PAGE_W-1:0] ringEndQ
);
  localparam logic [7:0] HDR_OFF = 8'(HDR_BYTES);

  logic [PAGE_W-1:0] boundaryQ;
  logic [ADDR_W-1:0] wrAddr;
  logic [15:0]       byteCnt;

  logic [ADDR_W-1:0] baseAddr, advAddr, startAddr;
  logic [PAGE_W-1:0] basePage, baseNext, finPage, finNext, nextPkt;
  logic [15:0]       totalLen;
  logic [7:0]        hdrByte;

  assign startAddr = {curPageQ, HDR_OFF};
  assign baseAddr  = ctl.useStart ? startAddr : wrAddr;
  assign basePage  = baseAddr[ADDR_W-1:8];
  assign finPage   = wrAddr[ADDR_W-1:8];

  rxring_page_inc #(.PAGE_W(PAGE_W)) u_incBase (
    .page(basePage), .ringStart(ringStartQ), .ringEnd(ringEndQ), .nextPage(baseNext)
  );

  rxring_page_inc #(.PAGE_W(PAGE_W)) u_incFin (
    .page(finPage), .ringStart(ringStartQ), .ringEnd(ringEndQ), .nextPage(finNext)
  );

  always_comb begin
    if (baseAddr[7:0] == 8'hFF) advAddr = {baseNext, 8'h00};
    else                        advAddr = baseAddr + {{(ADDR_W-1){1'b0}}, 1'b1};
    nextPkt  = (wrAddr[7:0] == 8'h00) ? finPage : finNext;
    totalLen = byteCnt + 16'(HDR_BYTES);
    unique case (ctl.hdrIdx)
      2'd0:    hdrByte = STATUS_OK;
      2'd1:    hdrByte = 8'(nextPkt);
      2'd2:    hdrByte = totalLen[7:0];
      default: hdrByte = totalLen[15:8];
    endcase
  end

  assign curHitsBnd = (curPageQ == boundaryQ);
  assign wrHitsBnd  = (finPage == boundaryQ);

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdata = ringStartQ;
      2'd1:    regRdata = ringEndQ;
      2'd2:    regRdata = boundaryQ;
      default: regRdata = curPageQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringStartQ <= PAGE_W'(START_RST);
      ringEndQ   <= PAGE_W'(END_RST);
      boundaryQ  <= PAGE_W'(BND_RST);
      curPageQ   <= PAGE_W'(CUR_RST);
    end else begin
      if (regWe && regAddr == 2'd0) ringStartQ <= regWdata;
      if (regWe && regAddr == 2'd1) ringEndQ   <= regWdata;
      if (regWe && regAddr == 2'd2) boundaryQ  <= regWdata;
      if (ctl.commit)                      curPageQ <= nextPkt;
      else if (regWe && regAddr == 2'd3)   curPageQ <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr  <= '0;
      byteCnt <= '0;
    end else begin
      if (ctl.rollback)       wrAddr <= startAddr;
      else if (ctl.writeByte) wrAddr <= advAddr;
      if (ctl.writeByte) byteCnt <= ctl.useStart ? 16'd1 : byteCnt + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWe        <= 1'b0;
      memAddr      <= '0;
      memData      <= '0;
      irqPktRcvd   <= 1'b0;
      irqOverwrite <= 1'b0;
    end else begin
      memWe        <= ctl.writeByte | ctl.hdrWrite;
      memAddr      <= ctl.hdrWrite ? {curPageQ, 6'd0, ctl.hdrIdx} : baseAddr;
      memData      <= ctl.hdrWrite ? hdrByte : rxData;
      irqPktRcvd   <= ctl.commit;
      irqOverwrite <= ctl.overflow;
    end
  end
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxring_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int HDR_BYTES = 4,
  parameter int START_RST = 'h40,
  parameter int END_RST   = 'h80,
  parameter int BND_RST   = 'h40,
  parameter int CUR_RST   = 'h41,
  localparam int PAGE_W   = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxSof,
  input  logic              rxEof,
  input  logic              rxGood,
  input  logic [7:0]        rxData,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [PAGE_W-1:0] regWdata,
  output logic [PAGE_W-1:0] regRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              irqPktRcvd,
  output logic              irqOverwrite
);
  ringCtl_t          ctl;
  logic              curHitsBnd, wrHitsBnd;
  logic [PAGE_W-1:0] curPageQ, ringStartQ, ringEndQ;

  rxring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .rxGood(rxGood), .curHitsBnd(curHitsBnd), .wrHitsBnd(wrHitsBnd), .ctl(ctl)
  );

  rxring_dp #(
    .ADDR_W(ADDR_W), .HDR_BYTES(HDR_BYTES), .STATUS_OK(8'h01),
    .START_RST(START_RST), .END_RST(END_RST), .BND_RST(BND_RST), .CUR_RST(CUR_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .irqPktRcvd(irqPktRcvd), .irqOverwrite(irqOverwrite),
    .curHitsBnd(curHitsBnd), .wrHitsBnd(wrHitsBnd),
    .curPageQ(curPageQ), .ringStartQ(ringStartQ), .ringEndQ(ringEndQ)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int PAGE_W = ADDR_W - 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irqPktRcvd,
  input logic              irqOverwrite,
  input logic [PAGE_W-1:0] curPageQ,
  input logic [PAGE_W-1:0] ringStartQ,
  input logic [PAGE_W-1:0] ringEndQ,
  input ringCtl_t          ctl
);
  logic dataQ, startQ, dataQQ;
  logic [PAGE_W-1:0] lastPage;

  assign lastPage = ringEndQ - {{(PAGE_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= 1'b0;
      dataQQ <= 1'b0;
      startQ <= 1'b0;
    end else begin
      dataQ  <= ctl.writeByte;
      dataQQ <= dataQ;
      startQ <= ctl.writeByte & ctl.useStart;
    end
  end

  // R1
  first_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> (memWe && memAddr[7:0] == 8'h04));

  // R2
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataQ && dataQQ && !startQ && $past(memAddr[7:0]) != 8'hFF)
      |-> (memAddr == $past(memAddr) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  // R3
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataQ && dataQQ && !startQ && $past(memAddr[7:0]) == 8'hFF &&
     $past(memAddr[ADDR_W-1:8]) == lastPage)
      |-> (memAddr[ADDR_W-1:8] == ringStartQ && memAddr[7:0] == 8'h00));

  // R4
  abort_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOverwrite |-> (!memWe && $stable(curPageQ)));

  // R6
  hdr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPktRcvd |-> ($past(memWe) && $past(memAddr[7:0]) == 8'h02));

  // R7
  commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPktRcvd |-> (memWe && memAddr[7:0] == 8'h03 &&
                    memAddr[ADDR_W-1:8] == $past(curPageQ)));

  // R7
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqPktRcvd, irqOverwrite}));
endmodule

bind rxring_mgr rxring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr),
  .irqPktRcvd(irqPktRcvd), .irqOverwrite(irqOverwrite),
  .curPageQ(curPageQ), .ringStartQ(ringStartQ), .ringEndQ(ringEndQ), .ctl(ctl)
);

// File: tb/rxring_mgr_tb.sv
module rxring_mgr_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 0, rxSof = 0, rxEof = 0, rxGood = 0;
  logic [7:0]  rxData = '0;
  logic        regWe = 0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic        irqPktRcvd, irqOverwrite;

  always #10 clk = ~clk;

  rxring_mgr u_dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .rxGood(rxGood), .rxData(rxData), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .irqPktRcvd(irqPktRcvd), .irqOverwrite(irqOverwrite)
  );

  int checks = 0, failures = 0;
  int pktCnt = 0, ovfCnt = 0, wrCnt = 0;
  int expPkt = 0, expOvf = 0;
  logic [23:0] expQ[$];
  string curReq = "R1";
  bit [7:0] mStart = 8'h40, mEnd = 8'h80, mBnd = 8'h40, mCur = 8'h41;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (memWe) begin
        wrCnt++;
        if (expQ.size() == 0) check(0, curReq, "unexpected write addr", int'(memAddr), 0);
        else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check({memAddr, memData} == e, curReq, "write addr/data",
                int'({memAddr, memData}), int'(e));
        end
      end
      if (irqPktRcvd) pktCnt++;
      if (irqOverwrite) ovfCnt++;
    end
  end

  function automatic bit [7:0] wrapInc(bit [7:0] p);
    bit [7:0] n;
    n = p + 8'd1;
    return (n == mEnd) ? mStart : n;
  endfunction

  task automatic writeReg(bit [1:0] a, bit [7:0] v);
    regWe = 1; regAddr = a; regWdata = v;
    @(negedge clk);
    regWe = 0;
    case (a)
      2'd0: mStart = v;
      2'd1: mEnd = v;
      2'd2: mBnd = v;
      default: mCur = v;
    endcase
  endtask

  task automatic readReg(bit [1:0] a, output bit [7:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic sendPacket(int len, bit good, bit [7:0] seed, string req);
    bit [15:0] addr, tgt;
    bit dead = 0;
    bit [7:0] d, rd;
    curReq = req;
    addr = '0;
    for (int i = 0; i < len; i++) begin
      d = seed + 8'(i);
      tgt = (i == 0) ? {mCur, 8'h04} : addr;
      if (!dead && tgt[15:8] == mBnd) begin
        dead = 1;
        expOvf++;
      end
      if (!dead) begin
        expQ.push_back({tgt, d});
        addr = (tgt[7:0] == 8'hFF) ? {wrapInc(tgt[15:8]), 8'h00} : tgt + 16'd1;
      end
      rxValid = 1; rxSof = (i == 0); rxEof = (i == len - 1); rxGood = good; rxData = d;
      @(negedge clk);
    end
    rxValid = 0; rxSof = 0; rxEof = 0; rxGood = 0;
    if (!dead && good) begin
      bit [7:0] nxt;
      bit [15:0] tot;
      nxt = (addr[7:0] == 8'h00) ? addr[15:8] : wrapInc(addr[15:8]);
      tot = 16'(len + 4);
      expQ.push_back({mCur, 8'h00, 8'h01});
      expQ.push_back({mCur, 8'h01, nxt});
      expQ.push_back({mCur, 8'h02, tot[7:0]});
      expQ.push_back({mCur, 8'h03, tot[15:8]});
      mCur = nxt;
      expPkt++;
    end
    repeat (8) @(negedge clk);
    check(pktCnt == expPkt, req, "packet-received pulses", pktCnt, expPkt);
    check(ovfCnt == expOvf, req, "overwrite pulses", ovfCnt, expOvf);
    check(expQ.size() == 0, req, "pending expected writes", expQ.size(), 0);
    readReg(2'd3, rd);
    check(rd == mCur, req, "current page", rd, mCur);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [7:0] v;
    int w0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R9 reset values
    readReg(2'd0, v); check(v == 8'h40, "R9", "ring start reset", v, 8'h40);
    readReg(2'd1, v); check(v == 8'h80, "R9", "ring end reset", v, 8'h80);
    readReg(2'd2, v); check(v == 8'h40, "R9", "boundary reset", v, 8'h40);
    readReg(2'd3, v); check(v == 8'h41, "R9", "current reset", v, 8'h41);
    check(memWe == 0 && irqPktRcvd == 0 && irqOverwrite == 0, "R9", "outputs idle", memWe, 0);

    // R8 stray beats
    curReq = "R8";
    w0 = wrCnt;
    for (int i = 0; i < 3; i++) begin
      rxValid = 1; rxData = 8'hA0 + 8'(i); rxEof = (i == 2); rxGood = 1;
      @(negedge clk);
    end
    rxValid = 0; rxEof = 0;
    repeat (4) @(negedge clk);
    check(wrCnt == w0, "R8", "writes from stray beats", wrCnt - w0, 0);

    // R1 R6 R7 short packet
    sendPacket(10, 1, 8'h10, "R6");
    // R2 page crossing
    sendPacket(300, 1, 8'h33, "R2");

    // R3 wrap from last ring page to start
    writeReg(2'd0, 8'h40);
    writeReg(2'd1, 8'h44);
    writeReg(2'd2, 8'h42);
    writeReg(2'd3, 8'h43);
    sendPacket(300, 1, 8'h55, "R3");

    // R5 rejected then good packet reusing the start
    sendPacket(20, 0, 8'h70, "R5");
    sendPacket(5, 1, 8'h90, "R5");

    // R4 cut off at the boundary in mid-packet
    writeReg(2'd2, 8'h41);
    sendPacket(900, 1, 8'h01, "R4");
    sendPacket(3, 1, 8'hC0, "R4");

    // R7 packet filling its page exactly, next page wraps
    sendPacket(252, 1, 8'hE0, "R7");
    readReg(2'd3, v); check(v == 8'h40, "R7", "next page after exact fill", v, 8'h40);

    // R4 boundary hit on the first byte
    writeReg(2'd2, 8'h40);
    sendPacket(5, 1, 8'h22, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule